// File: doc/BRIEF.md
# Fixed-Length Serial Frame Transmitter

This block sends one frame of exactly 1024 bytes from a local transmit buffer as a clock-and-data serial stream (SCK and MOSI). Software fills the buffer through a small CPU write port. The buffer holds every byte that goes on the wire, including the preamble and the frame check sequence, because the block generates neither. A write of any value to the trigger register starts the frame. A busy flag stays high until the last bit has left the block. The flag is available as a pin and as a bit of a status register.

Inside, a bit counter runs from the system clock. Its lowest bit is the serial clock phase, so SCK always runs at half the clock rate. Its carry advances a byte counter. The frame ends when the byte counter carries into its top bit, so no length comparator is needed. Each byte is read from the buffer into a holding register well before it is needed, and it is copied into the output shifter only at a byte boundary. SCK and MOSI both leave through one register stage, so they stay aligned. The CPU port has no back-pressure: every write is taken in the cycle it is presented. The serial output has no flow control either: once a frame starts, the receiver must accept one bit per two clocks.

Top module: `fixlen_serial_tx`

## Requirements
- R1: After reset, `tx_busy_o`, `sck_o` and `mosi_o` are low, and a status read returns 0x00.
- R2: A write with `cpu_addr[15:12]` = 0xF and `cpu_addr[11]` = 0 stores `cpu_wdata` in buffer byte `cpu_addr[9:0]`. A write with `cpu_addr[11]` = 1 leaves the buffer unchanged.
- R3: When the block is idle, a write of any value to address 0xFB01 sets `tx_busy_o` from the next clock cycle.
- R4: Each frame puts exactly 1024 bytes on the wire (8192 SCK rising edges), taken from buffer byte 0 upward.
- R5: Each byte is sent most significant bit first. MOSI is sampled on the rising edge of SCK.
- R6: SCK is high for exactly one clock and low for at least one clock, so it runs at no more than half the clock rate. SCK is low whenever `tx_busy_o` is low.
- R7: MOSI never changes while SCK is high. It changes only together with a falling SCK edge, or at the start of the frame.
- R8: `tx_busy_o` stays high for exactly 16388 cycles per frame: 3 cycles of prefetch, 16 cycles per byte, and 1 drain cycle that ends the last SCK pulse.
- R9: A write to 0xFB01 while `tx_busy_o` is high is ignored: the frame running at the time keeps its length and content.
- R10: A read at address 0xFB00 returns the busy flag in bit 1, with all other bits 0. Any other address reads as 0x00.
- R11: A write to 0xFB00, or to any address other than 0xFB01, does not start a frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; SCK is derived from it |
| rst_n | input | 1 | Active-low synchronous reset |
| cpu_addr | input | 16 | CPU address for writes and status reads |
| cpu_wdata | input | 8 | CPU write data |
| cpu_we | input | 1 | CPU write strobe, one write per cycle |
| cpu_rdata | output | 8 | Status read data (combinational on `cpu_addr`) |
| tx_busy_o | output | 1 | High from the cycle after a trigger until the frame is fully sent |
| sck_o | output | 1 | Serial clock, idle low |
| mosi_o | output | 1 | Serial data, MSB first, stable while SCK is high |

## Verification
A bit counter that is off by one shows up at the ports within a single byte time. The frame then either gains or loses SCK pulses, which changes the busy length, or it moves MOSI edges into the high phase of SCK. Both are seen within 16 cycles of the fault. A holding register or shifter loaded at the wrong moment corrupts the rebuilt byte stream at the first affected byte. A fault in the end-of-frame detection changes the busy window by a whole byte or more, or leaves the block running past 16388 cycles. Running one random frame and one directed frame (preamble, all-zero, all-one and single-bit bytes) exposes errors in bit order and in byte order.

// File: rtl/fltx_pkg.sv
package fltx_pkg;

  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_FETCH = 3'd1,
    ST_HOLD  = 3'd2,
    ST_LOAD  = 3'd3,
    ST_SEND  = 3'd4,
    ST_DRAIN = 3'd5
  } tx_state_e;

  // cycles spent before the first serial bit appears
  localparam int unsigned PRIME_CYCLES = 3;
  // cycles spent after the last bit to close the final SCK pulse
  localparam int unsigned DRAIN_CYCLES = 1;

endpackage

// File: rtl/fltx_addr_dec.sv
module fltx_addr_dec #(
  parameter int unsigned CPU_AW   = 16,
  parameter int unsigned BUF_AW   = 10,
  parameter logic [3:0]  WIN_NIB  = 4'hF,
  parameter logic [7:0]  REG_PAGE = 8'hFB,
  parameter logic [7:0]  STAT_OFS = 8'h00,
  parameter logic [7:0]  TRIG_OFS = 8'h01
) (
  input  logic [CPU_AW-1:0] cpu_addr,
  input  logic              cpu_we,
  output logic              buf_we,
  output logic [BUF_AW-1:0] buf_addr,
  output logic              trig_wr,
  output logic              stat_sel
);

  logic win_hit;
  logic buf_hit;
  logic page_hit;

  always_comb begin
    win_hit  = (cpu_addr[CPU_AW-1 -: 4] == WIN_NIB);
    buf_hit  = win_hit && !cpu_addr[CPU_AW-5];
    page_hit = (cpu_addr[CPU_AW-1 -: 8] == REG_PAGE);
    buf_we   = cpu_we && buf_hit;
    buf_addr = cpu_addr[BUF_AW-1:0];
    trig_wr  = cpu_we && page_hit && (cpu_addr[7:0] == TRIG_OFS);
    stat_sel = page_hit && (cpu_addr[7:0] == STAT_OFS);
  end

endmodule

// File: rtl/fltx_buf_ram.sv
module fltx_buf_ram #(
  parameter int unsigned DW = 8,
  parameter int unsigned AW = 10
) (
  input  logic          clk,
  input  logic          wr_en,
  input  logic [AW-1:0] wr_addr,
  input  logic [DW-1:0] wr_data,
  input  logic [AW-1:0] rd_addr,
  output logic [DW-1:0] rd_q
);

  localparam int unsigned DEPTH = 1 << AW;

  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (wr_en) mem[wr_addr] <= wr_data;
    rd_q <= mem[rd_addr];
  end

endmodule

// File: rtl/fltx_seq.sv
module fltx_seq
  import fltx_pkg::*;
#(
  parameter int unsigned DW       = 8,
  parameter int unsigned LEN_LOG2 = 10
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                trig_wr,
  output logic                busy,
  output logic                sending,
  output logic                sck_phase,
  output logic [LEN_LOG2-1:0] rd_addr,
  output logic                ld_hold,
  output logic                ld_shift,
  output logic                shift_en
);

  localparam int unsigned BCW  = $clog2(DW) + 1;
  localparam int unsigned BYW  = LEN_LOG2 + 1;
  localparam logic [BCW-1:0] HOLD_PH  = BCW'(DW);
  localparam logic [BCW-1:0] LAST_PH  = '1;

  tx_state_e      state;
  logic [BCW-1:0] bit_cnt;
  logic [BYW-1:0] byte_cnt;
  logic [BYW-1:0] byte_nxt;
  logic           wrap;
  logic           frame_end;

  always_comb begin
    byte_nxt  = byte_cnt + 1'b1;
    wrap      = (state == ST_SEND) && (bit_cnt == LAST_PH);
    frame_end = wrap && byte_nxt[LEN_LOG2];
    busy      = (state != ST_IDLE);
    sending   = (state == ST_SEND);
    sck_phase = bit_cnt[0];
    rd_addr   = (state == ST_SEND) ? byte_nxt[LEN_LOG2-1:0] : '0;
    ld_hold   = (state == ST_HOLD) ||
                ((state == ST_SEND) && (bit_cnt == HOLD_PH));
    ld_shift  = (state == ST_LOAD) || (wrap && !byte_nxt[LEN_LOG2]);
    shift_en  = (state == ST_SEND) && bit_cnt[0] && !wrap;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state    <= ST_IDLE;
      bit_cnt  <= '0;
      byte_cnt <= '0;
    end else begin
      unique case (state)
        ST_IDLE: begin
          if (trig_wr) begin
            state    <= ST_FETCH;
            bit_cnt  <= '0;
            byte_cnt <= '0;
          end
        end
        ST_FETCH: state <= ST_HOLD;
        ST_HOLD:  state <= ST_LOAD;
        ST_LOAD: begin
          state   <= ST_SEND;
          bit_cnt <= '0;
        end
        ST_SEND: begin
          bit_cnt <= bit_cnt + 1'b1;
          if (wrap) begin
            byte_cnt <= byte_nxt;
            if (frame_end) state <= ST_DRAIN;
          end
        end
        ST_DRAIN: state <= ST_IDLE;
        default:  state <= ST_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/fltx_shift_out.sv
module fltx_shift_out #(
  parameter int unsigned DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [DW-1:0] ram_q,
  input  logic          ld_hold,
  input  logic          ld_shift,
  input  logic          shift_en,
  input  logic          sending,
  input  logic          sck_phase,
  output logic          sck_o,
  output logic          mosi_o
);

  logic [DW-1:0] hold_q;
  logic [DW-1:0] shreg;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      hold_q <= '0;
      shreg  <= '0;
    end else begin
      if (ld_hold) hold_q <= ram_q;
      if (ld_shift)      shreg <= hold_q;
      else if (shift_en) shreg <= {shreg[DW-2:0], 1'b0};
    end
  end

  // clock and data share one register stage so they leave aligned
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sck_o  <= 1'b0;
      mosi_o <= 1'b0;
    end else begin
      sck_o  <= sending && sck_phase;
      mosi_o <= sending ? shreg[DW-1] : 1'b0;
    end
  end

endmodule

// File: rtl/fixlen_serial_tx.sv
module fixlen_serial_tx #(
  parameter int unsigned DATA_W   = 8,
  parameter int unsigned LEN_LOG2 = 10,
  parameter int unsigned CPU_AW   = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [CPU_AW-1:0] cpu_addr,
  input  logic [DATA_W-1:0] cpu_wdata,
  input  logic              cpu_we,
  output logic [DATA_W-1:0] cpu_rdata,
  output logic              tx_busy_o,
  output logic              sck_o,
  output logic              mosi_o
);

  localparam int unsigned BUSY_BIT = 1;

  logic                buf_we;
  logic [LEN_LOG2-1:0] buf_addr;
  logic                trig_wr;
  logic                stat_sel;
  logic [LEN_LOG2-1:0] rd_addr;
  logic [DATA_W-1:0]   ram_q;
  logic                busy;
  logic                sending;
  logic                sck_phase;
  logic                ld_hold;
  logic                ld_shift;
  logic                shift_en;

  fltx_addr_dec #(
    .CPU_AW (CPU_AW),
    .BUF_AW (LEN_LOG2)
  ) u_dec (
    .cpu_addr (cpu_addr),
    .cpu_we   (cpu_we),
    .buf_we   (buf_we),
    .buf_addr (buf_addr),
    .trig_wr  (trig_wr),
    .stat_sel (stat_sel)
  );

  fltx_buf_ram #(
    .DW (DATA_W),
    .AW (LEN_LOG2)
  ) u_ram (
    .clk     (clk),
    .wr_en   (buf_we),
    .wr_addr (buf_addr),
    .wr_data (cpu_wdata),
    .rd_addr (rd_addr),
    .rd_q    (ram_q)
  );

  fltx_seq #(
    .DW       (DATA_W),
    .LEN_LOG2 (LEN_LOG2)
  ) u_seq (
    .clk       (clk),
    .rst_n     (rst_n),
    .trig_wr   (trig_wr),
    .busy      (busy),
    .sending   (sending),
    .sck_phase (sck_phase),
    .rd_addr   (rd_addr),
    .ld_hold   (ld_hold),
    .ld_shift  (ld_shift),
    .shift_en  (shift_en)
  );

  fltx_shift_out #(
    .DW (DATA_W)
  ) u_out (
    .clk       (clk),
    .rst_n     (rst_n),
    .ram_q     (ram_q),
    .ld_hold   (ld_hold),
    .ld_shift  (ld_shift),
    .shift_en  (shift_en),
    .sending   (sending),
    .sck_phase (sck_phase),
    .sck_o     (sck_o),
    .mosi_o    (mosi_o)
  );

  always_comb begin
    tx_busy_o = busy;
    cpu_rdata = '0;
    if (stat_sel) cpu_rdata[BUSY_BIT] = busy;
  end

endmodule

// File: rtl/fltx_chk.sv
module fltx_chk #(
  parameter int unsigned DATA_W   = 8,
  parameter int unsigned LEN_LOG2 = 10
) (
  input logic clk,
  input logic rst_n,
  input logic trig_wr,
  input logic tx_busy,
  input logic sck,
  input logic mosi
);

  localparam int unsigned BUSY_CYCLES = 3 + 2 * DATA_W * (1 << LEN_LOG2) + 1;
  localparam int unsigned CW = $clog2(BUSY_CYCLES + 2);

  logic [CW-1:0] busy_cnt;

  always_ff @(posedge clk) begin
    if (!rst_n)       busy_cnt <= '0;
    else if (tx_busy) busy_cnt <= busy_cnt + 1'b1;
    else              busy_cnt <= '0;
  end

  AST_START_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    (!tx_busy && trig_wr) |=> tx_busy); // R3

  AST_BUSY_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    tx_busy |-> (busy_cnt < CW'(BUSY_CYCLES))); // R9

  AST_BUSY_LEN: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(tx_busy) |-> (busy_cnt == CW'(BUSY_CYCLES))); // R8

  AST_SCK_IDLE_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    !tx_busy |-> !sck); // R6

  AST_SCK_ONE_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    sck |=> !sck); // R6

  AST_MOSI_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    sck |-> $stable(mosi)); // R7

endmodule

bind fixlen_serial_tx fltx_chk #(
  .DATA_W   (DATA_W),
  .LEN_LOG2 (LEN_LOG2)
) u_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .trig_wr (trig_wr),
  .tx_busy (tx_busy_o),
  .sck     (sck_o),
  .mosi    (mosi_o)
);

// File: tb/fixlen_serial_tx_tb_top.sv
`timescale 1ns/1ps
module fixlen_serial_tx_tb_top;

  localparam int FRAME  = 1024;
  localparam int BUSY_N = 3 + 16 * FRAME + 1;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] cpu_addr = '0;
  logic [7:0]  cpu_wdata = '0;
  logic        cpu_we = 1'b0;
  logic [7:0]  cpu_rdata;
  logic        tx_busy_o;
  logic        sck_o;
  logic        mosi_o;

  always #2 clk = ~clk;

  fixlen_serial_tx dut_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .cpu_addr  (cpu_addr),
    .cpu_wdata (cpu_wdata),
    .cpu_we    (cpu_we),
    .cpu_rdata (cpu_rdata),
    .tx_busy_o (tx_busy_o),
    .sck_o     (sck_o),
    .mosi_o    (mosi_o)
  );

  int n_tests = 0;
  int n_fail  = 0;

  logic [7:0] exp_buf [FRAME];
  logic [7:0] cap_buf [FRAME];

  // serial monitor state, sampled on falling clock edges
  int   cap_n, cap_bits, busy_cycles, err_idle_sck, err_sck_long, err_mosi;
  logic [7:0] cap_byte;
  logic prev_sck, prev_mosi;

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic clear_mon();
    cap_n = 0; cap_bits = 0; busy_cycles = 0;
    err_idle_sck = 0; err_sck_long = 0; err_mosi = 0; cap_byte = '0;
  endtask

  always @(negedge clk) begin
    if (rst_n) begin
      if (tx_busy_o) busy_cycles++;
      if (!tx_busy_o && sck_o) err_idle_sck++;
      if (sck_o && prev_sck) err_sck_long++;
      if (sck_o && (mosi_o !== prev_mosi)) err_mosi++;
      if (sck_o && !prev_sck) begin
        cap_byte = {cap_byte[6:0], mosi_o};
        cap_bits++;
        if (cap_bits == 8) begin
          if (cap_n < FRAME) cap_buf[cap_n] = cap_byte;
          cap_n++;
          cap_bits = 0;
        end
      end
    end
    prev_sck  = sck_o;
    prev_mosi = mosi_o;
  end

  task automatic cpu_write(input logic [15:0] a, input logic [7:0] d);
    @(negedge clk);
    cpu_addr = a; cpu_wdata = d; cpu_we = 1'b1;
    @(negedge clk);
    cpu_we = 1'b0;
  endtask

  task automatic load_frame();
    for (int i = 0; i < FRAME; i++) cpu_write(16'hF000 + 16'(i), exp_buf[i]);
  endtask

  // start a frame, optionally retrigger mid-frame, wait, then check it
  task automatic run_frame(input string tag, input bit retrig);
    int wd;
    int bad;
    int first_bad;
    clear_mon();
    cpu_write(16'hFB01, 8'h00);
    chk(tx_busy_o === 1'b1, "R3", {tag, " busy after trigger"}, int'(tx_busy_o), 1);
    cpu_addr = 16'hFB00; #1;
    chk(cpu_rdata === 8'h02, "R10", {tag, " status while busy"}, int'(cpu_rdata), 2);
    if (retrig) begin
      repeat (5000) @(negedge clk);
      cpu_write(16'hFB01, 8'hA5); // R9: must be ignored
    end
    wd = 0;
    while (tx_busy_o && wd < 100000) begin @(negedge clk); wd++; end
    chk(wd < 100000, "R8", {tag, " watchdog"}, wd, 0);
    repeat (4) @(negedge clk);
    chk(busy_cycles == BUSY_N, retrig ? "R9" : "R8", {tag, " busy length"},
        busy_cycles, BUSY_N);
    chk(cap_n == FRAME && cap_bits == 0, "R4", {tag, " bytes on wire"}, cap_n, FRAME);
    bad = 0; first_bad = -1;
    for (int i = 0; i < FRAME; i++)
      if (cap_buf[i] !== exp_buf[i]) begin
        if (first_bad < 0) first_bad = i;
        bad++;
      end
    if (first_bad >= 0)
      $display("FAIL R5 %s byte %0d: actual %02h expected %02h", tag, first_bad,
               cap_buf[first_bad], exp_buf[first_bad]);
    n_tests++;
    if (bad != 0) n_fail++;
    chk(err_mosi == 0, "R7", {tag, " mosi moved while sck high"}, err_mosi, 0);
    chk(err_sck_long == 0, "R6", {tag, " sck high longer than a cycle"}, err_sck_long, 0);
    chk(err_idle_sck == 0, "R6", {tag, " sck high while idle"}, err_idle_sck, 0);
    chk(sck_o === 1'b0 && mosi_o === 1'b0, "R6", {tag, " idle lines"},
        int'({sck_o, mosi_o}), 0);
  endtask

  initial begin : watchdog
    repeat (190000) @(posedge clk);
    n_tests++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin : main
    void'($urandom(32'h5EED0101));
    clear_mon();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    cpu_addr = 16'hFB00; #1;
    chk(tx_busy_o === 1'b0 && sck_o === 1'b0 && mosi_o === 1'b0, "R1", "reset outputs",
        int'({tx_busy_o, sck_o, mosi_o}), 0);
    chk(cpu_rdata === 8'h00, "R1", "reset status", int'(cpu_rdata), 0);
    cpu_addr = 16'hFB02; #1;
    chk(cpu_rdata === 8'h00, "R10", "non-status read", int'(cpu_rdata), 0);

    // random frame
    for (int i = 0; i < FRAME; i++) exp_buf[i] = 8'($urandom);
    load_frame();
    // R2: writes with address bit 11 set must not reach the buffer
    cpu_write(16'hF805, ~exp_buf[5]);
    cpu_write(16'hFC10, ~exp_buf[16]);
    cpu_write(16'hFBFF, ~exp_buf[1023]);
    // R11: writes elsewhere do not start a frame
    cpu_write(16'hFB00, 8'hFF);
    cpu_write(16'hEB01, 8'h00);
    repeat (4) @(negedge clk);
    chk(tx_busy_o === 1'b0 && busy_cycles == 0, "R11", "no start from other address",
        busy_cycles, 0);
    run_frame("random(R2)", 1'b1);

    // directed frame: preamble, extremes, single-bit bytes
    for (int i = 0; i < FRAME; i++) exp_buf[i] = 8'(i * 37 + 11);
    for (int i = 0; i < 7; i++) exp_buf[i] = 8'h55;
    exp_buf[7] = 8'hD5; exp_buf[8] = 8'h00; exp_buf[9] = 8'hFF;
    exp_buf[10] = 8'h80; exp_buf[11] = 8'h01;
    exp_buf[FRAME-2] = 8'h01; exp_buf[FRAME-1] = 8'h80;
    load_frame();
    run_frame("directed(R5)", 1'b0);

    cpu_addr = 16'hFB00; #1;
    chk(cpu_rdata === 8'h00, "R10", "status after frame", int'(cpu_rdata), 0);

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule